// File: doc/BRIEF.md
# Byte-level I2C master with posted status codes

This block is an I2C bus master that performs exactly one bus event per software command: a START, a repeated START, one address or data byte with its acknowledge bit, one received byte with its acknowledge bit, or a STOP. When the event is finished the block posts a one-byte status code and sets a sticky event flag. It then keeps SCL low and leaves the bus idle until software clears that flag. Clearing the flag is what launches the next event. The byte or action it launches depends on the control bits and on the last status code.

Software reaches the block through a small write port with four registers. Offset 0 is control, offset 1 is data, offset 2 is the divider and offset 3 is a soft reset. The control, data and status contents are visible at output ports. Bus pins follow the open-drain convention: the block only pulls SCL or SDA low, and it reads the SDA line back. Each bit on the bus lasts ten phases of a programmable length. SCL is high in phases 5 to 8 of every data bit, and SDA moves only while SCL is low, except when it forms a START or a STOP.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset or soft reset, status reads 0xF8, the control register reads 0x00, and neither SCL nor SDA is pulled low.
- R2: The divider register holds M in bits [6:3] and N in bits [2:0]. One phase lasts (M+1)·2^(N+1) clock cycles. SCL rises once every ten phases while a byte is being shifted.
- R3: Control bit 5 (start) makes a START condition, posts 0x08 and sets the flag. When a transfer is already open it makes a repeated START and posts 0x10. The start bit clears itself when the condition is finished.
- R4: Control bit 3 is the event flag. Writing 0 to it clears it, and writing 1 to it has no effect. While the flag is set the block launches nothing, keeps SCL low and keeps the status unchanged. The irq output equals the flag AND control bit 7.
- R5: After a START (0x08 or 0x10), clearing the flag sends the data register MSB first as an address, with bit 0 as R/W. The posted status is 0x18 (write, ACK), 0x20 (write, NACK), 0x40 (read, ACK) or 0x48 (read, NACK).
- R6: After 0x18 or 0x28, clearing the flag sends the data register as a data byte. The posted status is 0x28 if the byte is acknowledged and 0x30 if it is not.
- R7: After 0x40 or 0x50, clearing the flag receives one byte into the data register. If control bit 2 is 1 the block returns ACK and posts 0x50. If control bit 2 is 0 it returns NACK and posts 0x58.
- R8: Control bit 4 (stop) makes a STOP condition during an open transfer. It then clears itself, posts 0xF8, leaves the flag clear and releases both lines.
- R9: Control bit 6 enables the block. While it is 0, the bus lines hold their state and pending start or stop requests wait.
- R10: A write to offset 3 aborts any event in progress, returns to the R1 state and keeps the divider value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register offset: 0 control, 1 data, 2 divider, 3 soft reset |
| wr_data | input | 8 | Register write value |
| ctrl_o | output | 8 | Control register contents |
| data_o | output | 8 | Data register contents |
| status_o | output | 8 | Last posted status code |
| irq_o | output | 1 | Event flag gated by interrupt enable |
| sda_i | input | 1 | SDA line level |
| scl_low_o | output | 1 | Pull SCL low when 1 |
| sda_low_o | output | 1 | Pull SDA low when 1 |

## Verification
The bench builds the block with its default divider field widths, 4 bits for M and 3 bits for N. Most traffic runs with M=0 and N=0, which gives 2-cycle phases. With those phases a whole byte with its acknowledge slot completes in 180 cycles, so random data streams, both acknowledge outcomes and every status code fit in a short run. One pass reprograms M=2 and N=1 to measure the 120-cycle SCL period, which tests the packed divider fields with non-zero exponents.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    // register offsets
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_DATA = 2'd1;
    localparam logic [1:0] A_BAUD = 2'd2;
    localparam logic [1:0] A_SRST = 2'd3;

    // control bit positions
    localparam int C_IE    = 7;
    localparam int C_EN    = 6;
    localparam int C_START = 5;
    localparam int C_STOP  = 4;
    localparam int C_FLAG  = 3;
    localparam int C_ACK   = 2;

    // posted status codes
    localparam logic [7:0] ST_STARTED  = 8'h08;
    localparam logic [7:0] ST_RESTART  = 8'h10;
    localparam logic [7:0] ST_AW_ACK   = 8'h18;
    localparam logic [7:0] ST_AW_NACK  = 8'h20;
    localparam logic [7:0] ST_DT_ACK   = 8'h28;
    localparam logic [7:0] ST_DT_NACK  = 8'h30;
    localparam logic [7:0] ST_AR_ACK   = 8'h40;
    localparam logic [7:0] ST_AR_NACK  = 8'h48;
    localparam logic [7:0] ST_RX_ACK   = 8'h50;
    localparam logic [7:0] ST_RX_NACK  = 8'h58;
    localparam logic [7:0] ST_IDLE     = 8'hF8;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_BIT   = 2'd2
    } bus_op_e;

    typedef enum logic [2:0] {
        SQ_READY = 3'd0,
        SQ_START = 3'd1,
        SQ_STOP  = 3'd2,
        SQ_TX    = 3'd3,
        SQ_RX    = 3'd4
    } seq_state_e;

endpackage

// File: rtl/i2cm_tick_gen.sv
module i2cm_tick_gen #(
    parameter int M_W = 4,
    parameter int N_W = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           run,
    input  logic           hold,
    input  logic [M_W-1:0] div_m,
    input  logic [N_W-1:0] div_n,
    output logic           tick
);
    localparam int CNT_W = M_W + (1 << N_W) + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q, lim;

    always_comb begin
        lim   = ((CNT_W'(div_m) + CNT_W'(1)) << div_n) << 1;
        lim   = lim - CNT_W'(1);
        tick  = run && !hold && (cnt_q == lim);
        cnt_d = cnt_q;
        if (clr || !run)      cnt_d = '0;
        else if (!hold)       cnt_d = (cnt_q == lim) ? '0 : cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2cm_bit_engine.sv
module i2cm_bit_engine
    import i2cm_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clr,
    input  logic    tick,
    input  logic    go,
    input  bus_op_e op,
    input  logic    bit_val,
    input  logic    sda_i,
    output logic    busy,
    output logic    done,
    output logic    rx_bit,
    output logic    scl_low,
    output logic    sda_low
);
    typedef struct packed {
        logic       busy;
        logic [3:0] ph;
        bus_op_e    op;
        logic       bitv;
        logic       scl_low;
        logic       sda_low;
        logic       rx;
        logic [1:0] sync;
    } eng_t;

    localparam eng_t ENG_RST = '{busy: 1'b0, ph: 4'd0, op: OP_BIT, bitv: 1'b1,
                                 scl_low: 1'b0, sda_low: 1'b0, rx: 1'b1, sync: 2'b11};

    eng_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[0], sda_i};
        done     = s_q.busy && tick && (s_q.ph == 4'd9);
        if (s_q.busy && tick) begin
            unique case (s_q.op)
                OP_START: begin
                    s_d.scl_low = (s_q.ph <= 4'd2) || (s_q.ph == 4'd9);
                    s_d.sda_low = (s_q.ph >= 4'd6);
                end
                OP_STOP: begin
                    s_d.scl_low = (s_q.ph <= 4'd2);
                    s_d.sda_low = (s_q.ph <= 4'd5);
                end
                default: begin
                    s_d.scl_low = (s_q.ph <= 4'd4) || (s_q.ph == 4'd9);
                    s_d.sda_low = !s_q.bitv;
                end
            endcase
            if (s_q.ph == 4'd7) s_d.rx = s_q.sync[1];
            if (s_q.ph == 4'd9) s_d.busy = 1'b0;
            else                s_d.ph   = s_q.ph + 4'd1;
        end
        if (go && (!s_q.busy || done)) begin
            s_d.busy = 1'b1;
            s_d.ph   = 4'd0;
            s_d.op   = op;
            s_d.bitv = bit_val;
        end
        if (clr) s_d = ENG_RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= ENG_RST;
        else        s_q <= s_d;
    end

    assign busy    = s_q.busy;
    assign rx_bit  = s_q.rx;
    assign scl_low = s_q.scl_low;
    assign sda_low = s_q.sda_low;
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2cm_pkg::*;
#(
    parameter int DIV_M_W = 4,
    parameter int DIV_N_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic [7:0] ctrl_o,
    output logic [7:0] data_o,
    output logic [7:0] status_o,
    output logic       irq_o,
    input  logic       sda_i,
    output logic       scl_low_o,
    output logic       sda_low_o
);
    localparam int BAUD_W = DIV_M_W + DIV_N_W;

    typedef struct packed {
        logic [7:0]        ctrl;
        logic [7:0]        data;
        logic [BAUD_W-1:0] baud;
        logic [7:0]        status;
        seq_state_e        st;
        logic [3:0]        cnt;
        logic [7:0]        sh;
        logic              in_xfer;
        logic              is_addr;
        logic              rd;
        logic              ack_out;
    } regs_t;

    localparam regs_t REGS_RST = '{ctrl: 8'h00, data: 8'h00, baud: '0, status: ST_IDLE,
                                   st: SQ_READY, cnt: 4'd0, sh: 8'h00, in_xfer: 1'b0,
                                   is_addr: 1'b0, rd: 1'b0, ack_out: 1'b0};

    regs_t   r_d, r_q;
    logic    go, bitv, srst, tick, eng_busy, eng_done, eng_rx;
    bus_op_e op;
    logic    tx_ok, rx_ok, ack_in;

    always_comb begin
        r_d    = r_q;
        go     = 1'b0;
        op     = OP_BIT;
        bitv   = 1'b1;
        srst   = wr_en && (wr_addr == A_SRST);
        ack_in = !eng_rx;
        tx_ok  = (r_q.status == ST_STARTED) || (r_q.status == ST_RESTART) ||
                 (r_q.status == ST_AW_ACK)  || (r_q.status == ST_DT_ACK);
        rx_ok  = (r_q.status == ST_AR_ACK)  || (r_q.status == ST_RX_ACK);

        if (wr_en) begin
            unique case (wr_addr)
                A_CTRL: begin
                    r_d.ctrl          = wr_data;
                    r_d.ctrl[C_START] = r_q.ctrl[C_START] | wr_data[C_START];
                    r_d.ctrl[C_STOP]  = r_q.ctrl[C_STOP]  | wr_data[C_STOP];
                    r_d.ctrl[C_FLAG]  = r_q.ctrl[C_FLAG]  & wr_data[C_FLAG];
                end
                A_DATA:  r_d.data = wr_data;
                A_BAUD:  r_d.baud = wr_data[BAUD_W-1:0];
                default: ;
            endcase
        end

        unique case (r_q.st)
            SQ_READY: if (r_q.ctrl[C_EN] && !r_q.ctrl[C_FLAG]) begin
                if (r_q.ctrl[C_START]) begin
                    go = 1'b1; op = OP_START; r_d.st = SQ_START;
                end else if (r_q.ctrl[C_STOP]) begin
                    if (r_q.in_xfer) begin
                        go = 1'b1; op = OP_STOP; r_d.st = SQ_STOP;
                    end else begin
                        r_d.ctrl[C_STOP] = 1'b0;
                    end
                end else if (r_q.in_xfer && tx_ok) begin
                    go          = 1'b1;
                    bitv        = r_q.data[7];
                    r_d.sh      = r_q.data << 1;
                    r_d.cnt     = 4'd0;
                    r_d.is_addr = (r_q.status == ST_STARTED) || (r_q.status == ST_RESTART);
                    r_d.rd      = r_q.data[0];
                    r_d.st      = SQ_TX;
                end else if (r_q.in_xfer && rx_ok) begin
                    go      = 1'b1;
                    r_d.cnt = 4'd0;
                    r_d.st  = SQ_RX;
                end
            end
            SQ_START: if (eng_done) begin
                r_d.status        = r_q.in_xfer ? ST_RESTART : ST_STARTED;
                r_d.in_xfer       = 1'b1;
                r_d.ctrl[C_START] = 1'b0;
                r_d.ctrl[C_FLAG]  = 1'b1;
                r_d.st            = SQ_READY;
            end
            SQ_STOP: if (eng_done) begin
                r_d.status       = ST_IDLE;
                r_d.in_xfer      = 1'b0;
                r_d.ctrl[C_STOP] = 1'b0;
                r_d.st           = SQ_READY;
            end
            SQ_TX: if (eng_done) begin
                if (r_q.cnt == 4'd8) begin
                    if (r_q.is_addr && r_q.rd) r_d.status = ack_in ? ST_AR_ACK : ST_AR_NACK;
                    else if (r_q.is_addr)      r_d.status = ack_in ? ST_AW_ACK : ST_AW_NACK;
                    else                       r_d.status = ack_in ? ST_DT_ACK : ST_DT_NACK;
                    r_d.ctrl[C_FLAG] = 1'b1;
                    r_d.st           = SQ_READY;
                end else begin
                    go      = 1'b1;
                    bitv    = (r_q.cnt == 4'd7) ? 1'b1 : r_q.sh[7];
                    r_d.sh  = r_q.sh << 1;
                    r_d.cnt = r_q.cnt + 4'd1;
                end
            end
            SQ_RX: if (eng_done) begin
                if (r_q.cnt == 4'd8) begin
                    r_d.data         = r_q.sh;
                    r_d.status       = r_q.ack_out ? ST_RX_ACK : ST_RX_NACK;
                    r_d.ctrl[C_FLAG] = 1'b1;
                    r_d.st           = SQ_READY;
                end else begin
                    go      = 1'b1;
                    r_d.sh  = {r_q.sh[6:0], eng_rx};
                    r_d.cnt = r_q.cnt + 4'd1;
                    if (r_q.cnt == 4'd7) begin
                        r_d.ack_out = r_q.ctrl[C_ACK];
                        bitv        = !r_q.ctrl[C_ACK];
                    end
                end
            end
            default: r_d.st = SQ_READY;
        endcase

        if (srst) begin
            r_d      = REGS_RST;
            r_d.baud = r_q.baud;
            go       = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    i2cm_tick_gen #(.M_W(DIV_M_W), .N_W(DIV_N_W)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (srst),
        .run   (eng_busy),
        .hold  (!r_q.ctrl[C_EN]),
        .div_m (r_q.baud[BAUD_W-1:DIV_N_W]),
        .div_n (r_q.baud[DIV_N_W-1:0]),
        .tick  (tick)
    );

    i2cm_bit_engine eng_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (srst),
        .tick    (tick),
        .go      (go),
        .op      (op),
        .bit_val (bitv),
        .sda_i   (sda_i),
        .busy    (eng_busy),
        .done    (eng_done),
        .rx_bit  (eng_rx),
        .scl_low (scl_low_o),
        .sda_low (sda_low_o)
    );

    assign ctrl_o   = r_q.ctrl;
    assign data_o   = r_q.data;
    assign status_o = r_q.status;
    assign irq_o    = r_q.ctrl[C_FLAG] & r_q.ctrl[C_IE];
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic [7:0] ctrl_o,
    input logic [7:0] status_o,
    input logic       scl_low_o,
    input logic       sda_low_o
);
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 8'hF8 && !ctrl_o[5]) |-> (!scl_low_o && !sda_low_o)); // R1

    AST_START_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ctrl_o[5]) && !$past(wr_en && wr_addr == 2'd3))
        |-> (ctrl_o[3] && (status_o == 8'h08 || status_o == 8'h10))); // R3

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o[3] && !wr_en) |=> (ctrl_o[3] && $stable(status_o))); // R4

    AST_FLAG_STALLS_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o[3] |-> scl_low_o); // R4

    AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_o[6] && !wr_en) |=> ($stable(scl_low_o) && $stable(sda_low_o))); // R9
endmodule

bind i2c_byte_master i2cm_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .ctrl_o    (ctrl_o),
    .status_o  (status_o),
    .scl_low_o (scl_low_o),
    .sda_low_o (sda_low_o)
);

// File: tb/i2c_byte_master_tb_top.sv
`timescale 1ns/1ps
module i2c_byte_master_tb_top;
    localparam logic [6:0] SLV = 7'h2A;
    localparam logic [7:0] NAK_BYTE = 8'hEE;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] ctrl_o, data_o, status_o;
    logic       irq_o, scl_low_o, sda_low_o;
    logic       s_drv = 1'b0;
    logic       scl_ln, sda_ln;
    int         errs = 0, checks = 0, cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign scl_ln = !scl_low_o;
    assign sda_ln = !(sda_low_o | s_drv);

    i2c_byte_master dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctrl_o(ctrl_o), .data_o(data_o), .status_o(status_o), .irq_o(irq_o),
        .sda_i(sda_ln), .scl_low_o(scl_low_o), .sda_low_o(sda_low_o)
    );

    function automatic logic [7:0] rd_byte(input int k);
        return 8'hA5 ^ 8'(k * 29);
    endfunction

    // behavioural target device
    logic       scl_p = 1'b1, sda_p = 1'b1;
    bit         s_act, s_rd, s_addr, rdreq, mack;
    int         bc, idx, rx_cnt;
    logic [7:0] sh, tx, last_rx;
    always @(posedge clk) begin
        scl_p <= scl_ln;
        sda_p <= sda_ln;
        if (scl_ln && scl_p && sda_p && !sda_ln) begin
            s_act = 1; s_addr = 1; s_rd = 0; bc = 0; s_drv <= 1'b0;
        end else if (scl_ln && scl_p && !sda_p && sda_ln) begin
            s_act = 0; s_drv <= 1'b0;
        end else if (s_act && scl_ln && !scl_p) begin
            if (!s_rd && bc < 8) sh = {sh[6:0], sda_ln};
            if (s_rd && bc == 8) mack = !sda_ln;
            bc++;
        end else if (s_act && !scl_ln && scl_p) begin
            if (bc == 8 && !s_rd) begin
                if (s_addr) begin
                    s_act = (sh[7:1] == SLV); rdreq = sh[0];
                    s_drv <= (sh[7:1] == SLV);
                end else begin
                    last_rx = sh; rx_cnt++;
                    s_drv <= (sh != NAK_BYTE);
                end
            end else if (bc == 9) begin
                bc = 0;
                if (s_addr) begin
                    s_addr = 0; s_rd = rdreq; idx = 0;
                    if (rdreq) begin tx = rd_byte(idx); idx++; s_drv <= !tx[7]; end
                    else s_drv <= 1'b0;
                end else if (s_rd) begin
                    if (mack) begin tx = rd_byte(idx); idx++; s_drv <= !tx[7]; end
                    else begin s_act = 0; s_drv <= 1'b0; end
                end else s_drv <= 1'b0;
            end else if (s_rd && bc >= 1 && bc <= 7) s_drv <= !tx[7-bc];
            else if (s_rd && bc == 8) s_drv <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic wait_flag();
        for (int i = 0; i < 4000 && !ctrl_o[3]; i++) @(negedge clk);
    endtask

    task automatic wait_stop();
        for (int i = 0; i < 4000 && ctrl_o[4]; i++) @(negedge clk);
        @(negedge clk);
    endtask

    // send one byte after clearing the flag, return posted status
    task automatic send(input logic [7:0] b, output logic [7:0] st);
        wr(2'd1, b); wr(2'd0, 8'hC4); wait_flag(); st = status_o;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin : main
        logic [7:0] st, b;
        int t0, t1;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(status_o == 8'hF8, "R1 status", status_o, 8'hF8);
        chk(ctrl_o == 8'h00, "R1 ctrl", ctrl_o, 0);
        chk(!scl_low_o && !sda_low_o, "R1 lines", {scl_low_o, sda_low_o}, 0);

        wr(2'd2, 8'h00);
        // R9 disabled: start waits
        wr(2'd0, 8'h20);
        repeat (100) @(negedge clk);
        chk(status_o == 8'hF8 && !scl_low_o && ctrl_o[5], "R9 disabled", status_o, 8'hF8);
        wr(2'd0, 8'hC4);
        wait_flag();
        chk(status_o == 8'h08, "R3 start", status_o, 8'h08);
        chk(!ctrl_o[5], "R3 start clears", ctrl_o, 8'hCC);
        chk(irq_o, "R4 irq", irq_o, 1);
        // R4 flag holds and stalls
        wr(2'd1, {SLV, 1'b0});
        repeat (200) @(negedge clk);
        chk(status_o == 8'h08 && scl_low_o, "R4 stall", status_o, 8'h08);
        wr(2'd0, 8'hC4); wait_flag();
        chk(status_o == 8'h18, "R5 write addr ack", status_o, 8'h18);
        // R6 random data bytes
        for (int i = 0; i < 6; i++) begin
            b = 8'($urandom);
            if (b == NAK_BYTE) b = 8'h3C;
            send(b, st);
            chk(st == 8'h28, "R6 data ack", st, 8'h28);
            chk(last_rx == b, "R6 byte seen", last_rx, b);
        end
        send(NAK_BYTE, st);
        chk(st == 8'h30, "R6 data nack", st, 8'h30);
        // R3 repeated start (also clears flag)
        wr(2'd0, 8'hE4); wait_flag();
        chk(status_o == 8'h10, "R3 repeated start", status_o, 8'h10);
        send({SLV, 1'b1}, st);
        chk(st == 8'h40, "R5 read addr ack", st, 8'h40);
        // R7 receive
        for (int k = 0; k < 4; k++) begin
            wr(2'd0, 8'hC4); wait_flag();
            chk(status_o == 8'h50, "R7 rx ack", status_o, 8'h50);
            chk(data_o == rd_byte(k), "R7 rx data", data_o, rd_byte(k));
        end
        wr(2'd0, 8'hC0); wait_flag();
        chk(status_o == 8'h58, "R7 rx nack", status_o, 8'h58);
        chk(data_o == rd_byte(4), "R7 last data", data_o, rd_byte(4));
        // R8 stop
        wr(2'd0, 8'hD4); wait_stop();
        chk(status_o == 8'hF8 && !ctrl_o[4] && !ctrl_o[3], "R8 stop", status_o, 8'hF8);
        chk(!scl_low_o && !sda_low_o, "R8 lines free", {scl_low_o, sda_low_o}, 0);
        wr(2'd0, 8'hCC);
        chk(!ctrl_o[3], "R4 flag write1 ignored", ctrl_o, 8'hC4);
        // R5 address nack cases
        wr(2'd0, 8'hE4); wait_flag();
        send(8'h66, st);
        chk(st == 8'h20, "R5 write addr nack", st, 8'h20);
        wr(2'd0, 8'hE4); wait_flag();
        send(8'h67, st);
        chk(st == 8'h48, "R5 read addr nack", st, 8'h48);
        wr(2'd0, 8'hD4); wait_stop();
        // R2 period with M=2 N=1
        wr(2'd2, 8'h11);
        wr(2'd0, 8'hE4); wait_flag();
        wr(2'd1, {SLV, 1'b0}); wr(2'd0, 8'hC4);
        @(posedge scl_ln); t0 = cyc;
        @(posedge scl_ln); t1 = cyc;
        chk(t1 - t0 == 120, "R2 scl period", t1 - t0, 120);
        wait_flag();
        chk(status_o == 8'h18, "R2 slow addr ack", status_o, 8'h18);
        // R10 soft reset mid byte, divider kept
        wr(2'd0, 8'hC4);
        repeat (300) @(negedge clk);
        wr(2'd3, 8'h00);
        chk(status_o == 8'hF8 && ctrl_o == 8'h00, "R10 soft reset", status_o, 8'hF8);
        chk(!scl_low_o && !sda_low_o, "R10 lines", {scl_low_o, sda_low_o}, 0);
        wr(2'd0, 8'hE4); wait_flag();
        wr(2'd1, {SLV, 1'b0}); wr(2'd0, 8'hC4);
        @(posedge scl_ln); t0 = cyc;
        @(posedge scl_ln); t1 = cyc;
        chk(t1 - t0 == 120, "R10 divider kept", t1 - t0, 120);
        wait_flag();
        wr(2'd0, 8'hD4); wait_stop();
        chk(status_o == 8'hF8, "R8 final stop", status_o, 8'hF8);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule